// File: doc/BRIEF.md
# Condition Flag Register and Branch Evaluator

This block keeps the four processor status flags (negative, zero, overflow, carry) and turns a 4-bit condition selector into a single take-branch decision. An execute stage feeds it the result word, carry-out and overflow of each ALU operation together with a write strobe and a per-flag mask. The mask lets an instruction class choose which flags it touches. For example, a shift can update only carry and a logical operation can leave overflow alone. A compare port takes two operands, forms their difference internally and loads all four flags from it. The compare port has priority over an ALU write in the same cycle.

The evaluator covers sixteen predicates: always and never, equality, signed and unsigned ordering, and the raw state of each flag. Codes are grouped in pairs, and the low selector bit inverts the pair's base predicate. When the `BYPASS` parameter is set, which is the default, the evaluator looks at the flag value being written in the current cycle. This lets a branch in the same cycle as its compare resolve without waiting. When `BYPASS` is clear, the evaluator looks only at the registered flags.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, all four flags read 0, even when a flag write is requested. Flag bit order is {N,Z,V,C}, with N at bit 3 and C at bit 0.
- R2: When `alu_wr` is 1 and `cmp_en` is 0, each flag whose mask bit is 1 loads from the ALU inputs at the next edge. N takes the result MSB, Z is set when the result is all zeros, V takes `alu_ovf` and C takes `alu_cout`. The mask bit positions match the flag bit positions.
- R3: A flag whose mask bit is 0 keeps its value during an ALU write.
- R4: When neither `alu_wr` nor `cmp_en` is 1, all four flags hold their value.
- R5: When `cmp_en` is 1, all four flags load from the difference `cmp_a - cmp_b`, whatever `alu_wr` and `alu_mask` are. N is the MSB of the difference. Z is set when the operands are equal. C is set when a borrow occurs, that is, when `cmp_a` < `cmp_b` unsigned. V is the signed overflow of the subtraction.
- R6: Selector codes 0 and 1 give always and never. For every code, setting the low bit returns the complement of the even code below it.
- R7: Codes 2/3 give Z and not Z. Codes 10/11 give C and not C. Codes 12/13 give N and not N. Codes 14/15 give V and not V.
- R8: Code 4 is less (N xor V) and code 5 is greater-or-equal. Code 6 is less-or-equal (Z or (N xor V)) and code 7 is greater. After a compare, these codes match the signed relation of the two operands.
- R9: Code 8 is unsigned less-or-equal (C or Z) and code 9 is unsigned greater. After a compare, these codes match the unsigned relation of the two operands.
- R10: With `BYPASS`=1, `take` in a cycle uses the flag value that is being written in that same cycle. `flags_q` shows that value from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_res | input | W | ALU result word |
| alu_cout | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| alu_wr | input | 1 | Flag write request from the ALU |
| alu_mask | input | 4 | Per-flag write mask {N,Z,V,C} |
| cmp_en | input | 1 | Explicit compare request |
| cmp_a | input | W | Compare left operand |
| cmp_b | input | W | Compare right operand |
| cond_sel | input | 4 | Condition selector |
| take | output | 1 | Predicate result |
| flags_q | output | 4 | Registered flags {N,Z,V,C} |

## Verification
The `take` output is combinational and, with bypass on, is due in the same cycle as the write that feeds it. The bench therefore drives the inputs just after a falling edge and samples `take` one nanosecond before the next rising edge. `flags_q` is due one edge after the write. It is checked at the following falling edge, before any new stimulus is applied. For the relational codes after a compare, the expected value comes directly from the signed or unsigned relation of the operands, not from the modelled flags. This keeps the borrow convention for carry consistent from end to end.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
   localparam int NFLAG = 4;
   localparam int FI_N  = 3;
   localparam int FI_Z  = 2;
   localparam int FI_V  = 1;
   localparam int FI_C  = 0;

   typedef logic [NFLAG-1:0] flags_t;

   typedef enum logic [3:0] {
      CC_AL  = 4'd0,  CC_NV  = 4'd1,
      CC_EQ  = 4'd2,  CC_NE  = 4'd3,
      CC_LT  = 4'd4,  CC_GE  = 4'd5,
      CC_LE  = 4'd6,  CC_GT  = 4'd7,
      CC_LEU = 4'd8,  CC_GTU = 4'd9,
      CC_CS  = 4'd10, CC_CC  = 4'd11,
      CC_MI  = 4'd12, CC_PL  = 4'd13,
      CC_VS  = 4'd14, CC_VC  = 4'd15
   } cond_e;
endpackage

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
   import cfu_pkg::*;
#(
   parameter int W               = 16,
   parameter bit CARRY_NO_BORROW = 1'b0
) (
   input  flags_t          cur,
   input  logic [W-1:0]    alu_res,
   input  logic            alu_cout,
   input  logic            alu_ovf,
   input  logic            alu_wr,
   input  logic [NFLAG-1:0] alu_mask,
   input  logic            cmp_en,
   input  logic [W-1:0]    cmp_a,
   input  logic [W-1:0]    cmp_b,
   output flags_t          nxt,
   output logic            wr
);
   localparam int MSB = W - 1;

   flags_t     alu_fl;
   flags_t     cmp_fl;
   flags_t     alu_merged;
   logic [W:0] diff;
   logic       borrow;

   if (W < 2) begin : g_bad_w
      $error("cfu_flag_next: W must be at least 2");
   end

   always_comb begin
      alu_fl        = '0;
      alu_fl[FI_N]  = alu_res[MSB];
      alu_fl[FI_Z]  = (alu_res == '0);
      alu_fl[FI_V]  = alu_ovf;
      alu_fl[FI_C]  = alu_cout;
   end

   assign diff   = {1'b0, cmp_a} - {1'b0, cmp_b};
   assign borrow = diff[W];

   always_comb begin
      cmp_fl       = '0;
      cmp_fl[FI_N] = diff[MSB];
      cmp_fl[FI_Z] = (cmp_a == cmp_b);
      cmp_fl[FI_V] = (cmp_a[MSB] != cmp_b[MSB]) && (diff[MSB] != cmp_a[MSB]);
   end

   flags_t cmp_full;
   if (CARRY_NO_BORROW) begin : g_c_noborrow
      always_comb begin
         cmp_full       = cmp_fl;
         cmp_full[FI_C] = ~borrow;
      end
   end else begin : g_c_borrow
      always_comb begin
         cmp_full       = cmp_fl;
         cmp_full[FI_C] = borrow;
      end
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_mask
      assign alu_merged[i] = alu_mask[i] ? alu_fl[i] : cur[i];
   end

   assign nxt = cmp_en ? cmp_full : (alu_wr ? alu_merged : cur);
   assign wr  = cmp_en | alu_wr;
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
   import cfu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr,
   input  flags_t nxt,
   output flags_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= nxt;
   end

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
   import cfu_pkg::*;
#(
   parameter bit CARRY_NO_BORROW = 1'b0
) (
   input  flags_t     fl,
   input  logic [3:0] sel,
   output logic       take
);
   logic nxv;
   logic leu;
   logic base;
   cond_e pair;

   assign nxv  = fl[FI_N] ^ fl[FI_V];
   assign pair = cond_e'({sel[3:1], 1'b0});

   if (CARRY_NO_BORROW) begin : g_leu_nb
      assign leu = ~fl[FI_C] | fl[FI_Z];
   end else begin : g_leu_b
      assign leu = fl[FI_C] | fl[FI_Z];
   end

   always_comb begin
      unique case (pair)
         CC_AL:   base = 1'b1;
         CC_EQ:   base = fl[FI_Z];
         CC_LT:   base = nxv;
         CC_LE:   base = fl[FI_Z] | nxv;
         CC_LEU:  base = leu;
         CC_CS:   base = fl[FI_C];
         CC_MI:   base = fl[FI_N];
         CC_VS:   base = fl[FI_V];
         default: base = 1'b0;
      endcase
   end

   assign take = base ^ sel[0];
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
   import cfu_pkg::*;
#(
   parameter int W               = 16,
   parameter bit BYPASS          = 1'b1,
   parameter bit CARRY_NO_BORROW = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] alu_res,
   input  logic         alu_cout,
   input  logic         alu_ovf,
   input  logic         alu_wr,
   input  logic [3:0]   alu_mask,
   input  logic         cmp_en,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] cmp_b,
   input  logic [3:0]   cond_sel,
   output logic         take,
   output logic [3:0]   flags_q
);
   flags_t cur;
   flags_t nxt;
   flags_t seen;
   logic   wr;

   cfu_flag_next #(.W(W), .CARRY_NO_BORROW(CARRY_NO_BORROW)) u_next (
      .cur(cur), .alu_res(alu_res), .alu_cout(alu_cout), .alu_ovf(alu_ovf),
      .alu_wr(alu_wr), .alu_mask(alu_mask), .cmp_en(cmp_en),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .nxt(nxt), .wr(wr)
   );

   cfu_flag_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr), .nxt(nxt), .q(cur)
   );

   if (BYPASS) begin : g_bypass
      assign seen = nxt;
   end else begin : g_registered
      assign seen = cur;
   end

   cfu_cond_eval #(.CARRY_NO_BORROW(CARRY_NO_BORROW)) u_eval (
      .fl(seen), .sel(cond_sel), .take(take)
   );

   assign flags_q = cur;

   // R3: unmasked flags keep their value across an ALU write
   for (genvar i = 0; i < NFLAG; i++) begin : g_chk
      p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (alu_wr && !cmp_en && !alu_mask[i]) |=> (flags_q[i] == $past(flags_q[i])));
   end

   p_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == 4'd0) |-> take);
   p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == 4'd1) |-> !take);
   p_cmp_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_a == cmp_b) |=> flags_q[FI_Z]);
   p_cmp_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_a < cmp_b) |=> (flags_q[FI_C] == !CARRY_NO_BORROW));
   p_reset_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (flags_q == 4'd0));
endmodule

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] alu_res = '0;
   logic         alu_cout = 1'b0, alu_ovf = 1'b0, alu_wr = 1'b0, cmp_en = 1'b0;
   logic [3:0]   alu_mask = '0, cond_sel = '0;
   logic [W-1:0] cmp_a = '0, cmp_b = '0;
   logic         take;
   logic [3:0]   flags_q;

   int n_run = 0, n_fail = 0;
   logic [3:0] model = '0;

   always #4 clk = ~clk;

   cond_flag_unit #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_cout(alu_cout),
      .alu_ovf(alu_ovf), .alu_wr(alu_wr), .alu_mask(alu_mask), .cmp_en(cmp_en),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .cond_sel(cond_sel), .take(take), .flags_q(flags_q)
   );

   function automatic logic [3:0] f_next(logic [3:0] c);
      logic [3:0] a;
      logic [W:0] d;
      if (cmp_en) begin
         d = {1'b0, cmp_a} - {1'b0, cmp_b};
         return {d[W-1], cmp_a == cmp_b,
                 (cmp_a[W-1] != cmp_b[W-1]) && (d[W-1] != cmp_a[W-1]), cmp_a < cmp_b};
      end
      if (!alu_wr) return c;
      a = {alu_res[W-1], alu_res == '0, alu_ovf, alu_cout};
      return (a & alu_mask) | (c & ~alu_mask);
   endfunction

   function automatic logic f_eval(logic [3:0] s, logic [3:0] f);
      logic n, z, v, c, b;
      {n, z, v, c} = f;
      case (s[3:1])
         3'd0: b = 1'b1;
         3'd1: b = z;
         3'd2: b = n ^ v;
         3'd3: b = z | (n ^ v);
         3'd4: b = c | z;
         3'd5: b = c;
         3'd6: b = n;
         default: b = v;
      endcase
      return b ^ s[0];
   endfunction

   function automatic logic f_rel(logic [3:0] s, logic [W-1:0] a, logic [W-1:0] b);
      case (s)
         4'd2: return a == b;
         4'd3: return a != b;
         4'd4: return $signed(a) <  $signed(b);
         4'd5: return $signed(a) >= $signed(b);
         4'd6: return $signed(a) <= $signed(b);
         4'd7: return $signed(a) >  $signed(b);
         4'd8: return a <= b;
         default: return a > b;
      endcase
   endfunction

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pick();
      case ($urandom_range(0, 5))
         0: return '0;
         1: return {1'b1, {(W-1){1'b0}}};
         2: return {1'b0, {(W-1){1'b1}}};
         3: return '1;
         default: return W'($urandom);
      endcase
   endfunction

   // one cycle: inputs already driven after negedge
   task automatic step(string req);
      logic [3:0] nx;
      nx = f_next(model);
      #3;
      chk({req, " take"}, {3'b0, take}, {3'b0, f_eval(cond_sel, nx)});
      @(negedge clk);
      model = nx;
      chk({req, " flags"}, flags_q, model);
   endtask

   task automatic idle();
      alu_wr = 0; cmp_en = 0; alu_mask = '0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      // R1: reset dominates a write request
      @(negedge clk);
      alu_wr = 1; alu_mask = 4'hF; alu_res = '0; alu_cout = 1; alu_ovf = 1;
      @(negedge clk);
      chk("R1 reset", flags_q, 4'h0);
      @(negedge clk);
      chk("R1 reset", flags_q, 4'h0);
      idle(); rst_n = 1;

      // R2: full-mask write of zero result with carry and overflow
      alu_wr = 1; alu_mask = 4'hF; alu_res = '0; alu_cout = 1; alu_ovf = 1; cond_sel = 4'd2;
      step("R2");
      chk("R2 zcv", flags_q, 4'b0111);
      // R3: shift-like write touches only carry
      alu_res = {1'b1, {(W-1){1'b0}}}; alu_cout = 0; alu_ovf = 0; alu_mask = 4'b0001;
      cond_sel = 4'd10;
      step("R3");
      chk("R3 carry only", flags_q, 4'b0110);
      // R4: nothing written, outputs stay
      idle(); alu_res = '0; alu_cout = 1; cond_sel = 4'd3;
      step("R4");
      chk("R4 hold", flags_q, 4'b0110);
      // R5: compare overrides ALU write; 0x8000 - 1 overflows signed
      alu_wr = 1; alu_mask = 4'hF; cmp_en = 1;
      cmp_a = {1'b1, {(W-1){1'b0}}}; cmp_b = 1; cond_sel = 4'd4;
      step("R5");
      chk("R5 cmp", flags_q, 4'b0010);
      // R5/R9: 1 - 2 borrows
      idle(); cmp_en = 1; cmp_a = 1; cmp_b = 2; cond_sel = 4'd8;
      step("R9");
      chk("R5 borrow", flags_q, 4'b1001);

      // R6/R7/R8/R9/R10: compare and branch in the same cycle, all relational codes
      for (int k = 0; k < 400; k++) begin
         idle(); cmp_en = 1; cmp_a = pick(); cmp_b = ($urandom_range(0, 3) == 0) ? cmp_a : pick();
         cond_sel = 4'(2 + $urandom_range(0, 7));
         #3;
         chk(cond_sel < 4 ? "R7 eq" : (cond_sel < 8 ? "R8 signed" : "R9 unsigned"),
             {3'b0, take}, {3'b0, f_rel(cond_sel, cmp_a, cmp_b)});
         @(negedge clk);
         model = f_next(model);
      end
      idle(); cmp_en = 1; cmp_a = 5; cmp_b = 5; cond_sel = 4'd2;
      step("R10 bypass");

      // random mix, every code including R6 always/never and R7 raw flags
      for (int k = 0; k < 3000; k++) begin
         alu_wr = $urandom_range(0, 1); cmp_en = ($urandom_range(0, 3) == 0);
         alu_mask = 4'($urandom); alu_res = pick();
         alu_cout = $urandom_range(0, 1); alu_ovf = $urandom_range(0, 1);
         cmp_a = pick(); cmp_b = pick(); cond_sel = 4'($urandom);
         step(cond_sel < 2 ? "R6" : "R7 R2 R3 R4 R5");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule